// File: doc/BRIEF.md
# Word/Byte Host Register Port

This block is the host-facing register port of a data converter. A host reaches it over a parallel bus with an active-low chip select, active-low read and write strobes, and a mode pin that picks full-word or byte-wide transfers. Every write delivers a 16-bit word. The top two bits of that word name the target register and the low 14 bits are the payload stored there. A word arrives either in one transfer on all sixteen lines or as two byte transfers on the low eight lines, with data line 8 acting as the high-byte enable.

Reads carry no address. Bits 7:6 of the control register hold a read selector that stays in force until the next control write. The selector picks the conversion result, the test register, a small file of calibration words, or the converter status. The calibration file is reached through one shared pointer. A control write sets the pointer back to the first entry, each complete calibration access moves it on by one, and it wraps after the last entry. The block holds the control, test and calibration storage. The converter core supplies the result and status words.

All strobes are sampled on the rising clock edge. Each cycle in which chip select and a strobe are both low counts as one transfer.

Top module: `conv_reg_port`

## Requirements
- R1: After reset the control register, the test register and the calibration pointer are zero, so the read selector is 00 and the first read returns the conversion result.
- R2: In word mode (mode pin high) one write cycle takes bus lines 15..0 as the word, with line 0 as LSB. The payload appears on the register outputs after the clock edge that ends the write cycle.
- R3: In byte mode (mode pin low) a write with line 8 low latches lines 7..0 as the low byte. A later write with line 8 high supplies the high byte and commits the word. A high byte with no low byte pending is ignored, and a word-mode write clears any pending low byte.
- R4: Word bits 15:14 route the payload. 11 goes to control, 10 goes to the calibration entry at the pointer, 01 goes to the test register, and 00 is discarded.
- R5: The read selector in control bits 7:6 picks the read word. 00 gives the conversion result zero-extended, 01 gives the test register, 10 gives the calibration entry at the pointer, and 11 gives the status word.
- R6: The read selector keeps its value across any number of reads and non-control writes.
- R7: bus_oe is high only in a cycle where chip select and read are both low, and bus_out is all zero whenever bus_oe is low.
- R8: A control write sets the calibration pointer to entry 0. A complete calibration write or read moves it to the next entry, wrapping from the last entry to entry 0. Calibration reads return the 14-bit entry with two leading zeros.
- R9: In byte mode a read places the low byte of the selected word on lines 7..0 when line 8 is low, or the high byte when line 8 is high. Lines 15..8 read zero. A calibration byte read advances the pointer only on the high byte.
- R10: Write and read strobes have no effect while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| word_mode | input | 1 | 1: 16-bit transfers, 0: byte transfers |
| bus_in | input | 16 | Write data from the host; line 8 is the high-byte enable in byte mode |
| bus_out | output | 16 | Read data to the host |
| bus_oe | output | 1 | High while the port drives bus_out |
| result_in | input | 12 | Latest conversion result from the converter core |
| status_in | input | 16 | Status word from the converter core |
| ctrl_o | output | 14 | Control register contents |
| test_o | output | 14 | Test register contents (no function inside the block) |

## Verification
Full-word writes are compared with split byte writes that carry the same word. This shows whether assembly puts the low byte first and commits only on the high byte. Stray high bytes and a word write placed between the two bytes separate a correct pending flag from one that reuses a stale low byte. Calibration entries are given distinct values and read back word by word past the last entry and then byte by byte. This shows that the pointer resets on control writes, wraps at the end, and advances on the high byte only. Reads of each selector code, writes to the discarded address, and strobes with chip select high show that routing and output enable follow only the intended signals.

// File: rtl/conv_port_pkg.sv
// Package: shared codes for the word/byte register port.
// Assumes a two-bit register address carried in the top bits of each word.
package conv_port_pkg;
    typedef enum logic [1:0] {
        DST_NONE = 2'b00,
        DST_TEST = 2'b01,
        DST_CAL  = 2'b10,
        DST_CTRL = 2'b11
    } dst_e;

    typedef enum logic [1:0] {
        RSEL_RESULT = 2'b00,
        RSEL_TEST   = 2'b01,
        RSEL_CAL    = 2'b10,
        RSEL_STATUS = 2'b11
    } rsel_e;
endpackage

// File: rtl/cp_write_assembler.sv
// Write assembler: turns word or byte write cycles into one committed word.
// Assumes a write cycle is any clock with the write event high. In byte mode
// line BYTE_W of bus_in is the high-byte enable. A commit is a combinational
// pulse in the cycle of the completing write.
module cp_write_assembler #(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_evt,
    input  logic             word_mode,
    input  logic [BUS_W-1:0] bus_in,
    output logic             commit_o,
    output logic [BUS_W-1:0] word_o,
    output logic             pending_o
);
    localparam int BYTE_W = BUS_W / 2;

    logic              pend_q;
    logic [BYTE_W-1:0] low_q;
    logic              hben;

    assign hben = bus_in[BYTE_W];

    // Hold the low byte until its high byte arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            low_q  <= '0;
        end else if (wr_evt) begin
            if (word_mode) begin
                pend_q <= 1'b0;
            end else if (!hben) begin
                pend_q <= 1'b1;
                low_q  <= bus_in[BYTE_W-1:0];
            end else begin
                pend_q <= 1'b0;
            end
        end
    end

    // Commit a full word, or a high byte that follows a stored low byte.
    always_comb begin
        commit_o = wr_evt && (word_mode || (hben && pend_q));
        if (word_mode) begin
            word_o = bus_in;
        end else begin
            word_o = {bus_in[BYTE_W-1:0], low_q};
        end
    end

    assign pending_o = pend_q;
endmodule

// File: rtl/cp_cal_file.sv
// Calibration file: CAL_REGS entries behind one auto-advancing pointer.
// Assumes no write and read complete in the same cycle. A pointer clear
// takes priority over an advance.
module cp_cal_file #(
    parameter int CAL_REGS = 10,
    parameter int PAY_W    = 14,
    localparam int PTR_W   = (CAL_REGS > 1) ? $clog2(CAL_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_clr,
    input  logic             wr_en,
    input  logic [PAY_W-1:0] wr_data,
    input  logic             rd_done,
    output logic [PAY_W-1:0] rd_data,
    output logic [PTR_W-1:0] ptr_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(CAL_REGS - 1);

    logic [PAY_W-1:0] mem_q [CAL_REGS];
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_next;

    // Next pointer value with wrap at the last entry.
    always_comb begin
        ptr_next = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    // Pointer: clear on control write, advance on each complete access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_clr) begin
            ptr_q <= '0;
        end else if (wr_en || rd_done) begin
            ptr_q <= ptr_next;
        end
    end

    // Storage: one entry per generate slot, written at the pointer.
    for (genvar gi = 0; gi < CAL_REGS; gi++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[gi] <= '0;
            end else if (wr_en && (ptr_q == PTR_W'(gi))) begin
                mem_q[gi] <= wr_data;
            end
        end
    end

    assign rd_data = mem_q[ptr_q];
    assign ptr_o   = ptr_q;
endmodule

// File: rtl/cp_read_mux.sv
// Read mux: picks the read word by selector and places it, or one byte of
// it, on the output lines. Assumes the read event is already qualified by
// chip select. The output is zero whenever the bus is not driven.
module cp_read_mux
    import conv_port_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int PAY_W = 14,
    parameter int RES_W = 12
) (
    input  logic             rd_evt,
    input  logic             word_mode,
    input  logic             hben,
    input  rsel_e            rsel,
    input  logic [RES_W-1:0] result_in,
    input  logic [BUS_W-1:0] status_in,
    input  logic [PAY_W-1:0] test_q,
    input  logic [PAY_W-1:0] cal_q,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe,
    output logic             cal_rd_done
);
    localparam int BYTE_W = BUS_W / 2;

    logic [BUS_W-1:0] word_sel;

    // Choose the source word for the current selector.
    always_comb begin
        unique case (rsel)
            RSEL_RESULT: word_sel = {{(BUS_W-RES_W){1'b0}}, result_in};
            RSEL_TEST:   word_sel = {{(BUS_W-PAY_W){1'b0}}, test_q};
            RSEL_CAL:    word_sel = {{(BUS_W-PAY_W){1'b0}}, cal_q};
            default:     word_sel = status_in;
        endcase
    end

    // Drive the word or the requested byte while a read is active.
    always_comb begin
        bus_oe = rd_evt;
        if (!rd_evt) begin
            bus_out = '0;
        end else if (word_mode) begin
            bus_out = word_sel;
        end else if (hben) begin
            bus_out = {{BYTE_W{1'b0}}, word_sel[BUS_W-1:BYTE_W]};
        end else begin
            bus_out = {{BYTE_W{1'b0}}, word_sel[BYTE_W-1:0]};
        end
    end

    // A calibration read is complete on a word read or a high-byte read.
    always_comb begin
        cal_rd_done = rd_evt && (rsel == RSEL_CAL) && (word_mode || hben);
    end
endmodule

// File: rtl/conv_reg_port.sv
// Top: host register port of a converter. It qualifies the strobes,
// assembles writes, routes payloads by the address in the word and
// serves reads from the register picked by the sticky selector.
// Assumes rd and wr are not asserted together in one cycle.
module conv_reg_port
    import conv_port_pkg::*;
#(
    parameter int BUS_W    = 16,
    parameter int ADDR_W   = 2,
    parameter int RES_W    = 12,
    parameter int CAL_REGS = 10,
    parameter int SEL_LSB  = 6,
    localparam int PAY_W   = BUS_W - ADDR_W,
    localparam int PTR_W   = (CAL_REGS > 1) ? $clog2(CAL_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             word_mode,
    input  logic [BUS_W-1:0] bus_in,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe,
    input  logic [RES_W-1:0] result_in,
    input  logic [BUS_W-1:0] status_in,
    output logic [PAY_W-1:0] ctrl_o,
    output logic [PAY_W-1:0] test_o
);
    localparam int BYTE_W = BUS_W / 2;

    logic             wr_evt;
    logic             rd_evt;
    logic             commit;
    logic [BUS_W-1:0] commit_word;
    logic             byte_pending;
    dst_e             dst;
    logic [PAY_W-1:0] payload;
    logic [PAY_W-1:0] ctrl_q;
    logic [PAY_W-1:0] test_q;
    logic [PAY_W-1:0] cal_q;
    logic [PTR_W-1:0] cal_ptr;
    logic             cal_rd_done;
    rsel_e            rsel;

    // Qualify the strobes with chip select.
    always_comb begin
        wr_evt = !cs_n && !wr_n;
        rd_evt = !cs_n && !rd_n;
    end

    cp_write_assembler #(.BUS_W(BUS_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_evt    (wr_evt),
        .word_mode (word_mode),
        .bus_in    (bus_in),
        .commit_o  (commit),
        .word_o    (commit_word),
        .pending_o (byte_pending)
    );

    // Split the committed word into address and payload.
    always_comb begin
        dst     = dst_e'(commit_word[BUS_W-1 -: ADDR_W]);
        payload = commit_word[PAY_W-1:0];
    end

    // Control and test storage; address 00 is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            test_q <= '0;
        end else if (commit) begin
            case (dst)
                DST_CTRL: ctrl_q <= payload;
                DST_TEST: test_q <= payload;
                default:  ;
            endcase
        end
    end

    cp_cal_file #(.CAL_REGS(CAL_REGS), .PAY_W(PAY_W)) u_cal (
        .clk     (clk),
        .rst_n   (rst_n),
        .ptr_clr (commit && (dst == DST_CTRL)),
        .wr_en   (commit && (dst == DST_CAL)),
        .wr_data (payload),
        .rd_done (cal_rd_done),
        .rd_data (cal_q),
        .ptr_o   (cal_ptr)
    );

    // Read selector taken from the control register.
    always_comb begin
        rsel = rsel_e'(ctrl_q[SEL_LSB +: 2]);
    end

    cp_read_mux #(.BUS_W(BUS_W), .PAY_W(PAY_W), .RES_W(RES_W)) u_rmux (
        .rd_evt      (rd_evt),
        .word_mode   (word_mode),
        .hben        (bus_in[BYTE_W]),
        .rsel        (rsel),
        .result_in   (result_in),
        .status_in   (status_in),
        .test_q      (test_q),
        .cal_q       (cal_q),
        .bus_out     (bus_out),
        .bus_oe      (bus_oe),
        .cal_rd_done (cal_rd_done)
    );

    assign ctrl_o = ctrl_q;
    assign test_o = test_q;
endmodule

// File: rtl/cp_port_checker.sv
// Checker: temporal properties of the register port, bound to the top.
module cp_port_checker #(
    parameter int BUS_W    = 16,
    parameter int CAL_REGS = 10,
    localparam int PAY_W   = BUS_W - 2,
    localparam int PTR_W   = (CAL_REGS > 1) ? $clog2(CAL_REGS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             wr_n,
    input logic             word_mode,
    input logic [BUS_W-1:0] bus_in,
    input logic [BUS_W-1:0] bus_out,
    input logic             bus_oe,
    input logic [PAY_W-1:0] ctrl_o,
    input logic [PAY_W-1:0] test_o,
    input logic             commit,
    input logic [BUS_W-1:0] commit_word,
    input logic             byte_pending,
    input logic [PTR_W-1:0] cal_ptr
);
    localparam int BYTE_W = BUS_W / 2;

    // R7: nothing appears on the data lines while the bus is not driven
    assert_quiet_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == '0));

    // R10: chip select high keeps the bus undriven
    assert_cs_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !bus_oe);

    // R6: the control register changes only after a control commit
    assert_ctrl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && (commit_word[BUS_W-1 -: 2] == 2'b11)) |=> $stable(ctrl_o));

    // R3: a high byte with no low byte pending changes no register
    assert_stray_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && !word_mode && bus_in[BYTE_W] && !byte_pending)
        |=> ($stable(ctrl_o) && $stable(test_o)));

    // R8: the pointer stays inside the file
    assert_ptr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cal_ptr) < CAL_REGS);

    // R8: a control commit returns the pointer to entry 0
    assert_ptr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (commit_word[BUS_W-1 -: 2] == 2'b11)) |=> (cal_ptr == '0));

    // R9: byte-mode reads leave the upper lines at zero
    assert_byte_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && !word_mode) |-> (bus_out[BUS_W-1:BYTE_W] == '0));
endmodule

bind conv_reg_port cp_port_checker #(.BUS_W(BUS_W), .CAL_REGS(CAL_REGS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .wr_n         (wr_n),
    .word_mode    (word_mode),
    .bus_in       (bus_in),
    .bus_out      (bus_out),
    .bus_oe       (bus_oe),
    .ctrl_o       (ctrl_o),
    .test_o       (test_o),
    .commit       (commit),
    .commit_word  (commit_word),
    .byte_pending (byte_pending),
    .cal_ptr      (cal_ptr)
);

// File: tb/conv_reg_port_bench.sv
`timescale 1ns/1ps
module conv_reg_port_bench;
    localparam int CAL_REGS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        word_mode = 1'b1;
    logic [15:0] bus_in = '0;
    logic [15:0] bus_out;
    logic        bus_oe;
    logic [11:0] result_in = 12'hA5C;
    logic [15:0] status_in = 16'hBEEF;
    logic [13:0] ctrl_o;
    logic [13:0] test_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    logic [13:0] m_ctrl;
    logic [13:0] m_test;
    logic [13:0] m_cal [CAL_REGS];
    int          m_ptr;
    bit          m_pend;
    logic [7:0]  m_low;

    always #2.5 clk = ~clk;

    conv_reg_port #(.CAL_REGS(CAL_REGS)) u_conv_reg_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .word_mode(word_mode), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .result_in(result_in), .status_in(status_in),
        .ctrl_o(ctrl_o), .test_o(test_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model: update on every rising edge from the sampled inputs.
    always @(posedge clk) begin
        logic [15:0] w;
        bit          c;
        c = 0;
        w = '0;
        if (!rst_n) begin
            m_ctrl = '0; m_test = '0; m_ptr = 0; m_pend = 0; m_low = '0;
            for (int i = 0; i < CAL_REGS; i++) m_cal[i] = '0;
        end else begin
            if (!cs_n && !wr_n) begin
                if (word_mode) begin
                    w = bus_in; c = 1; m_pend = 0;
                end else if (!bus_in[8]) begin
                    m_pend = 1; m_low = bus_in[7:0];
                end else if (m_pend) begin
                    w = {bus_in[7:0], m_low}; c = 1; m_pend = 0;
                end
                if (c) begin
                    case (w[15:14])
                        2'b11: begin m_ctrl = w[13:0]; m_ptr = 0; end
                        2'b10: begin m_cal[m_ptr] = w[13:0]; m_ptr = (m_ptr + 1) % CAL_REGS; end
                        2'b01: m_test = w[13:0];
                        default: ;
                    endcase
                end
            end
            if (!cs_n && !rd_n && m_ctrl[7:6] == 2'b10 && (word_mode || bus_in[8]))
                m_ptr = (m_ptr + 1) % CAL_REGS;
        end
    end

    function automatic logic [15:0] model_bus();
        logic [15:0] w;
        case (m_ctrl[7:6])
            2'b00:   w = {4'h0, result_in};
            2'b01:   w = {2'b00, m_test};
            2'b10:   w = {2'b00, m_cal[m_ptr]};
            default: w = status_in;
        endcase
        if (cs_n || rd_n) return 16'h0;
        if (word_mode) return w;
        return bus_in[8] ? {8'h0, w[15:8]} : {8'h0, w[7:0]};
    endfunction

    // Compare the design with the model once inputs have settled each cycle.
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R7 bus_oe per cycle", {15'h0, bus_oe}, {15'h0, (!cs_n && !rd_n)});
            chk("R5 bus_out per cycle", bus_out, model_bus());
            chk("R2 ctrl per cycle", {2'b00, ctrl_o}, {2'b00, m_ctrl});
            chk("R4 test per cycle", {2'b00, test_o}, {2'b00, m_test});
        end
    end

    task automatic wr_word(input logic [15:0] w);
        word_mode = 1; bus_in = w; cs_n = 0; wr_n = 0; rd_n = 1;
        @(negedge clk);
        cs_n = 1; wr_n = 1;
    endtask

    task automatic wr_byte(input logic [7:0] b, input logic hb);
        word_mode = 0; bus_in = {7'h0, hb, b}; cs_n = 0; wr_n = 0; rd_n = 1;
        @(negedge clk);
        cs_n = 1; wr_n = 1;
    endtask

    task automatic rd_chk(input logic wm, input logic hb, input logic [15:0] exp, input string tag);
        word_mode = wm; bus_in = {7'h0, hb, 8'h00}; cs_n = 0; rd_n = 0; wr_n = 1;
        #2;
        chk(tag, bus_out, exp);
        chk(tag, {15'h0, bus_oe}, 16'h1);
        @(negedge clk);
        cs_n = 1; rd_n = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ctrl after reset", {2'b00, ctrl_o}, 16'h0);
        chk("R1 test after reset", {2'b00, test_o}, 16'h0);
        chk("R7 idle oe", {15'h0, bus_oe}, 16'h0);
        rst_n = 1;
        @(negedge clk);
        rd_chk(1, 0, 16'h0A5C, "R1 R5 default result read");

        // R7 / R10: partial selects
        cs_n = 1; rd_n = 0; #1;
        chk("R10 cs high read oe", {15'h0, bus_oe}, 16'h0);
        chk("R7 cs high read data", bus_out, 16'h0);
        @(negedge clk);
        cs_n = 0; rd_n = 1; #1;
        chk("R7 read high oe", {15'h0, bus_oe}, 16'h0);
        @(negedge clk);
        cs_n = 1;

        // R2 word write to control, selector 11
        wr_word(16'hC0C0);
        chk("R2 word control write", {2'b00, ctrl_o}, 16'h00C0);
        rd_chk(1, 0, 16'hBEEF, "R5 status read");
        wr_word(16'h5234);
        chk("R4 test write", {2'b00, test_o}, 16'h1234);
        rd_chk(1, 0, 16'hBEEF, "R6 selector kept after test write");
        status_in = 16'h1357;
        rd_chk(1, 0, 16'h1357, "R6 selector kept across reads");

        // R4 discarded address
        wr_word(16'h3FFF);
        chk("R4 addr 00 ctrl", {2'b00, ctrl_o}, 16'h00C0);
        chk("R4 addr 00 test", {2'b00, test_o}, 16'h1234);

        // R5 test readback
        wr_word(16'hC040);
        rd_chk(1, 0, 16'h1234, "R5 test readback");

        // R3 byte write
        wr_byte(8'hBC, 0);
        chk("R3 low byte alone", {2'b00, test_o}, 16'h1234);
        wr_byte(8'h6A, 1);
        chk("R3 byte pair commit", {2'b00, test_o}, 16'h2ABC);
        wr_byte(8'hC0, 1);
        chk("R3 stray high byte", {2'b00, ctrl_o}, 16'h0040);
        wr_byte(8'h11, 0);
        wr_word(16'h5234);
        wr_byte(8'hC0, 1);
        chk("R3 word clears pending", {2'b00, ctrl_o}, 16'h0040);
        chk("R3 word write between bytes", {2'b00, test_o}, 16'h1234);

        // R8 calibration file
        wr_word(16'hC080);
        wr_word(16'hA155);
        wr_word(16'h8A3C);
        wr_word(16'hBFF0);
        wr_word(16'hC080);
        rd_chk(1, 0, 16'h2155, "R8 cal entry 0");
        rd_chk(1, 0, 16'h0A3C, "R8 cal entry 1");
        rd_chk(1, 0, 16'h3FF0, "R8 cal entry 2");
        for (int i = 3; i < CAL_REGS; i++) rd_chk(1, 0, 16'h0000, "R8 cal unwritten entry");
        rd_chk(1, 0, 16'h2155, "R8 cal wrap");

        // R9 byte reads of calibration data
        wr_word(16'hC080);
        rd_chk(0, 0, 16'h0055, "R9 cal low byte");
        rd_chk(0, 0, 16'h0055, "R9 low byte does not advance");
        rd_chk(0, 1, 16'h0021, "R9 cal high byte");
        rd_chk(0, 0, 16'h003C, "R9 next entry low byte");
        rd_chk(0, 1, 16'h000A, "R9 next entry high byte");

        wr_word(16'hC0C0);
        rd_chk(0, 1, 16'h0013, "R9 status high byte");
        rd_chk(0, 0, 16'h0057, "R9 status low byte");

        // R10 write with chip select high
        word_mode = 1; bus_in = 16'hC3FF; cs_n = 1; wr_n = 0;
        @(negedge clk);
        wr_n = 1;
        chk("R10 write ignored", {2'b00, ctrl_o}, 16'h00C0);

        // R3 byte write to control, back to result selector
        wr_byte(8'h00, 0);
        wr_byte(8'hC0, 1);
        chk("R3 byte control write", {2'b00, ctrl_o}, 16'h0000);
        rd_chk(1, 0, 16'h0A5C, "R5 result after byte control write");

        @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule